// File: doc/BRIEF.md
# Two-Channel Transmit Frame Buffer

This block sits between a register bus and a byte-wide transmit stream. It holds two byte queues of equal size. Software chooses the queue that receives data with a select register, writes frame contents as 32-bit words through one shared data address, and programs a byte count for each queue. Writing a start command for a queue then sends that many bytes, one per accepted handshake, onto a valid/ready output stream. The stream flags the final byte of each frame.

A send never runs past the bytes that are actually held. When a frame finishes, its queue and byte count are emptied, and that queue's completion flag is set in the interrupt status register. The status bits are cleared by writing ones. A level interrupt is raised whenever an enabled status bit is set. One bit in the control register clears the whole block in a single write.

Top module: `txbuf_ctrl`

## Requirements
- R1: The register addresses are 0 control (bit 0 soft reset, bit 1 transmit enable), 1 queue select, 2 data, 3 and 4 byte count for queue 0 and queue 1, 5 and 6 start for queue 0 and queue 1 (a read returns that queue's fill level in bytes), 7 interrupt enable, and 8 interrupt status (bit 0 is queue 0, bit 1 is queue 1). After reset every readable value is zero, and tx_valid and irq are low.
- R2: Writing 0 or 1 to the select register selects that queue. Any value of 2 or more selects queue 0. The register reads back the selected queue.
- R3: A data write appends the word's 4 bytes to the selected queue, least significant byte first. If fewer than 4 bytes are free in that queue, the write is dropped and the fill level does not change.
- R4: A byte-count write larger than DEPTH stores DEPTH. Any other value is stored as written.
- R5: A start write begins a frame only if its bit 0 is set, transmit enable is set, no frame is in progress, and the effective length is non-zero. The effective length is the smaller of the byte count and the fill level. Any other start write has no effect.
- R6: A frame sends the effective length's bytes in queue order, one per cycle with tx_valid and tx_ready both high. tx_last is high on the final byte. After the final byte, that queue's fill level and byte count are zero, and any leftover bytes are discarded.
- R7: When a frame on queue c ends, status bit c is set.
- R8: irq is high exactly when the AND of the status and enable registers is non-zero. It follows any register change by the next cycle.
- R9: A status write clears each status bit that is 1 in the written value. A completion in the same cycle still sets its bit.
- R10: A control write with bit 0 set clears both queues, all registers and any frame in progress. Bit 0 is not stored, while bit 1 of the same write is stored as transmit enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 4 | Write address |
| reg_wdata | input | 32 | Write data |
| reg_raddr | input | 4 | Read address |
| reg_rdata | output | 32 | Read data, combinational |
| tx_valid | output | 1 | Output byte valid |
| tx_ready | input | 1 | Sink accepts byte |
| tx_data | output | 8 | Output byte |
| tx_last | output | 1 | Final byte of frame |
| irq | output | 1 | Level interrupt |

## Verification
Frames are sent with the sink always ready and with a repeating stall pattern. Both runs must give the same byte order, which separates handshake timing from queue ordering. Counts below, equal to and above the fill level, a count above DEPTH, and a data write into a full queue separate the two limits on frame length. Start writes with transmit disabled, with a zero count, or while another frame is running must produce no frame. A soft reset in the middle of a frame must cut the stream and keep the enable bit from the same write. A cycle-accurate model in the bench checks the stream outputs and irq on every cycle.

// File: rtl/txb_pkg.sv
package txb_pkg;
    localparam int NCH    = 2;
    localparam int ADDR_W = 4;

    typedef enum logic [ADDR_W-1:0] {
        RA_CTRL  = 4'd0,
        RA_CHSEL = 4'd1,
        RA_DATA  = 4'd2,
        RA_LEN0  = 4'd3,
        RA_LEN1  = 4'd4,
        RA_KICK0 = 4'd5,
        RA_KICK1 = 4'd6,
        RA_IEN   = 4'd7,
        RA_ISTAT = 4'd8
    } reg_addr_e;

    localparam int CTRL_RST_BIT  = 0;
    localparam int CTRL_TXEN_BIT = 1;
endpackage

// File: rtl/txb_fifo.sv
module txb_fifo #(
    parameter int DEPTH = 64,
    localparam int PW = $clog2(DEPTH),
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          push,
    input  logic [31:0]   push_word,
    input  logic          pop,
    output logic [7:0]    head,
    output logic [CW-1:0] level
);
    typedef struct packed {
        logic [PW-1:0] wp;
        logic [PW-1:0] rp;
        logic [CW-1:0] cnt;
    } fifo_st_t;

    fifo_st_t s_d, s_q;
    logic [7:0] mem [DEPTH];

    always_comb begin
        s_d = s_q;
        if (clr) begin
            s_d = '0;
        end else begin
            if (push) s_d.wp = s_q.wp + PW'(4);
            if (pop)  s_d.rp = s_q.rp + PW'(1);
            s_d.cnt = s_q.cnt + (push ? CW'(4) : CW'(0)) - (pop ? CW'(1) : CW'(0));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    always_ff @(posedge clk) begin
        if (push && !clr) begin
            for (int b = 0; b < 4; b++) begin
                mem[s_q.wp + PW'(b)] <= push_word[8*b +: 8];
            end
        end
    end

    assign head  = mem[s_q.rp];
    assign level = s_q.cnt;

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !clr) |-> (int'(s_q.cnt) <= DEPTH - 4)); // R3
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !clr) |-> (s_q.cnt != '0)); // R6
endmodule

// File: rtl/txb_sender.sv
module txb_sender #(
    parameter int NCH = 2,
    parameter int LW  = 7,
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          abort,
    input  logic          start,
    input  logic [SW-1:0] start_ch,
    input  logic [LW-1:0] start_len,
    input  logic          ready,
    output logic          valid,
    output logic          last,
    output logic [SW-1:0] ch,
    output logic          pop,
    output logic          done
);
    typedef struct packed {
        logic          busy;
        logic [SW-1:0] ch;
        logic [LW-1:0] rem;
    } snd_st_t;

    snd_st_t s_d, s_q;

    always_comb begin
        pop  = s_q.busy && ready;
        done = pop && (s_q.rem == LW'(1));
        s_d  = s_q;
        if (abort) begin
            s_d = '0;
        end else if (start) begin
            s_d.busy = 1'b1;
            s_d.ch   = start_ch;
            s_d.rem  = start_len;
        end else if (pop) begin
            s_d.rem = s_q.rem - LW'(1);
            if (done) s_d.busy = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign valid = s_q.busy;
    assign last  = s_q.busy && (s_q.rem == LW'(1));
    assign ch    = s_q.ch;

    AST_BUSY_HAS_BYTES: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.rem != '0)); // R6
    AST_NO_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        start |-> !s_q.busy); // R5
endmodule

// File: rtl/txbuf_ctrl.sv
module txbuf_ctrl
    import txb_pkg::*;
#(
    parameter int DEPTH = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_waddr,
    input  logic [31:0]       reg_wdata,
    input  logic [ADDR_W-1:0] reg_raddr,
    output logic [31:0]       reg_rdata,
    output logic              tx_valid,
    input  logic              tx_ready,
    output logic [7:0]        tx_data,
    output logic              tx_last,
    output logic              irq
);
    localparam int LW = $clog2(DEPTH + 1);
    localparam int SW = (NCH > 1) ? $clog2(NCH) : 1;

    typedef struct packed {
        logic                   txen;
        logic [SW-1:0]          sel;
        logic [NCH-1:0][LW-1:0] len;
        logic [NCH-1:0]         ien;
        logic [NCH-1:0]         stat;
    } regs_t;

    regs_t r_d, r_q;

    logic [NCH-1:0][LW-1:0] lvl;
    logic [NCH-1:0][LW-1:0] eff_len;
    logic [NCH-1:0][7:0]    head;
    logic [NCH-1:0]         push_v, pop_v, clr_v;
    logic                   soft_rst;
    logic                   kick_go;
    logic [SW-1:0]          kick_ch;
    logic [LW-1:0]          kick_len;
    logic                   snd_busy, snd_last, snd_pop, snd_done;
    logic [SW-1:0]          snd_ch;

    for (genvar c = 0; c < NCH; c++) begin : g_q
        txb_fifo #(.DEPTH(DEPTH)) u_fifo (
            .clk       (clk),
            .rst_n     (rst_n),
            .clr       (clr_v[c]),
            .push      (push_v[c]),
            .push_word (reg_wdata),
            .pop       (pop_v[c]),
            .head      (head[c]),
            .level     (lvl[c])
        );
    end

    txb_sender #(.NCH(NCH), .LW(LW)) u_snd (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (soft_rst),
        .start     (kick_go),
        .start_ch  (kick_ch),
        .start_len (kick_len),
        .ready     (tx_ready),
        .valid     (snd_busy),
        .last      (snd_last),
        .ch        (snd_ch),
        .pop       (snd_pop),
        .done      (snd_done)
    );

    // Queue control and start qualification
    always_comb begin
        soft_rst = reg_we && (reg_waddr == RA_CTRL) && reg_wdata[CTRL_RST_BIT];
        kick_go  = 1'b0;
        kick_ch  = '0;
        kick_len = '0;
        for (int c = 0; c < NCH; c++) begin
            eff_len[c] = (r_q.len[c] < lvl[c]) ? r_q.len[c] : lvl[c];
            push_v[c]  = reg_we && (reg_waddr == RA_DATA) && (r_q.sel == SW'(c))
                         && ((DEPTH - int'(lvl[c])) >= 4) && !soft_rst;
            pop_v[c]   = snd_pop && (snd_ch == SW'(c));
            clr_v[c]   = soft_rst || (snd_done && (snd_ch == SW'(c)));
            if (reg_we && (reg_waddr == ADDR_W'(RA_KICK0) + ADDR_W'(c)) && reg_wdata[0]
                && r_q.txen && !snd_busy && (eff_len[c] != '0) && !soft_rst) begin
                kick_go  = 1'b1;
                kick_ch  = SW'(c);
                kick_len = eff_len[c];
            end
        end
    end

    // Register next state
    always_comb begin
        r_d = r_q;
        for (int c = 0; c < NCH; c++) begin
            if (snd_done && (snd_ch == SW'(c))) r_d.len[c] = '0;
        end
        if (reg_we) begin
            case (reg_waddr)
                RA_CTRL:  r_d.txen = reg_wdata[CTRL_TXEN_BIT];
                RA_CHSEL: r_d.sel  = (reg_wdata < NCH) ? reg_wdata[SW-1:0] : '0;
                RA_IEN:   r_d.ien  = reg_wdata[NCH-1:0];
                RA_ISTAT: r_d.stat = r_q.stat & ~reg_wdata[NCH-1:0];
                default:  ;
            endcase
            for (int c = 0; c < NCH; c++) begin
                if (reg_waddr == ADDR_W'(RA_LEN0) + ADDR_W'(c)) begin
                    r_d.len[c] = (reg_wdata > DEPTH) ? LW'(DEPTH) : reg_wdata[LW-1:0];
                end
            end
        end
        if (snd_done) r_d.stat[snd_ch] = 1'b1;
        if (soft_rst) begin
            r_d      = '0;
            r_d.txen = reg_wdata[CTRL_TXEN_BIT];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    // Read side
    always_comb begin
        reg_rdata = '0;
        case (reg_raddr)
            RA_CTRL:  reg_rdata[CTRL_TXEN_BIT] = r_q.txen;
            RA_CHSEL: reg_rdata[SW-1:0]  = r_q.sel;
            RA_LEN0:  reg_rdata[LW-1:0]  = r_q.len[0];
            RA_LEN1:  reg_rdata[LW-1:0]  = r_q.len[1];
            RA_KICK0: reg_rdata[LW-1:0]  = lvl[0];
            RA_KICK1: reg_rdata[LW-1:0]  = lvl[1];
            RA_IEN:   reg_rdata[NCH-1:0] = r_q.ien;
            RA_ISTAT: reg_rdata[NCH-1:0] = r_q.stat;
            default:  ;
        endcase
    end

    assign tx_valid = snd_busy;
    assign tx_last  = snd_last;
    assign tx_data  = head[snd_ch];
    assign irq      = |(r_q.stat & r_q.ien);

    AST_TX_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tx_valid) |-> $past(r_q.txen)); // R5
    AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_done && !soft_rst) |=> r_q.stat[$past(snd_ch)]); // R7
    AST_DONE_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        (snd_done && !soft_rst) |=> (lvl[$past(snd_ch)] == '0)); // R6
    AST_SOFT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
        soft_rst |=> (!tx_valid && (r_q.stat == '0) && (lvl == '0))); // R10
    AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.ien == '0) |-> !irq); // R8
endmodule

// File: tb/txbuf_ctrl_test.sv
`timescale 1ns/1ps
module txbuf_ctrl_test;
    localparam int DEPTH = 64;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_waddr = '0;
    logic [31:0] reg_wdata = '0;
    logic [3:0]  reg_raddr = '0;
    logic [31:0] reg_rdata;
    logic        tx_valid, tx_last, irq;
    logic        tx_ready = 1'b0;
    logic [7:0]  tx_data;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    txbuf_ctrl #(.DEPTH(DEPTH)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
        .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata),
        .tx_valid(tx_valid), .tx_ready(tx_ready), .tx_data(tx_data),
        .tx_last(tx_last), .irq(irq)
    );

    // ---------------- reference model ----------------
    logic [7:0] q0[$];
    logic [7:0] q1[$];
    int  m_len [2];
    int  m_txen, m_sel, m_ien, m_stat;
    bit  m_busy;
    int  m_ch, m_rem;

    function automatic int fill(int c);
        return (c == 0) ? q0.size() : q1.size();
    endfunction

    function automatic logic [7:0] front(int c);
        if (c == 0) return (q0.size() > 0) ? q0[0] : 8'h00;
        return (q1.size() > 0) ? q1[0] : 8'h00;
    endfunction

    task automatic m_clear_all();
        q0.delete(); q1.delete();
        m_len[0] = 0; m_len[1] = 0;
        m_txen = 0; m_sel = 0; m_ien = 0; m_stat = 0;
        m_busy = 0; m_ch = 0; m_rem = 0;
    endtask

    function automatic logic [31:0] m_read(int a);
        case (a)
            0: return 32'(m_txen << 1);
            1: return 32'(m_sel);
            3: return 32'(m_len[0]);
            4: return 32'(m_len[1]);
            5: return 32'(q0.size());
            6: return 32'(q1.size());
            7: return 32'(m_ien);
            8: return 32'(m_stat);
            default: return 32'h0;
        endcase
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_clear_all();
        end else if (reg_we && reg_waddr == 4'd0 && reg_wdata[0]) begin
            m_clear_all();
            m_txen = int'(reg_wdata[1]);
        end else begin
            bit pb;
            bit done;
            int dch;
            int pf [2];
            int pl [2];
            int psel;
            int eff;
            int wc;
            pb = m_busy; pf[0] = q0.size(); pf[1] = q1.size();
            pl[0] = m_len[0]; pl[1] = m_len[1]; psel = m_sel;
            done = 0; dch = 0;
            if (m_busy && tx_ready) begin
                if (m_ch == 0) void'(q0.pop_front()); else void'(q1.pop_front());
                m_rem--;
                if (m_rem == 0) begin
                    m_busy = 0; done = 1; dch = m_ch; m_len[dch] = 0;
                end
            end
            if (reg_we) begin
                case (reg_waddr)
                    4'd0: m_txen = int'(reg_wdata[1]);
                    4'd1: m_sel = (reg_wdata < 2) ? int'(reg_wdata) : 0;
                    4'd2: if (DEPTH - pf[psel] >= 4) begin
                        for (int b = 0; b < 4; b++) begin
                            if (psel == 0) q0.push_back(reg_wdata[8*b +: 8]);
                            else           q1.push_back(reg_wdata[8*b +: 8]);
                        end
                    end
                    4'd3, 4'd4: begin
                        wc = int'(reg_waddr) - 3;
                        m_len[wc] = (reg_wdata > DEPTH) ? DEPTH : int'(reg_wdata);
                    end
                    4'd5, 4'd6: begin
                        wc = int'(reg_waddr) - 5;
                        eff = (pl[wc] < pf[wc]) ? pl[wc] : pf[wc];
                        if (reg_wdata[0] && m_txen != 0 && !pb && eff != 0) begin
                            m_busy = 1; m_ch = wc; m_rem = eff;
                        end
                    end
                    4'd7: m_ien = int'(reg_wdata[1:0]);
                    4'd8: m_stat = m_stat & ~int'(reg_wdata[1:0]);
                    default: ;
                endcase
            end
            if (done) begin
                if (dch == 0) q0.delete(); else q1.delete();
                m_stat = m_stat | (1 << dch);
            end
        end
    end

    // ---------------- checking ----------------
    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk("R5 tx_valid", 32'(tx_valid), 32'(m_busy));
            chk("R8 irq", 32'(irq), 32'((m_stat & m_ien) != 0));
            if (m_busy) begin
                chk("R6 tx_data", 32'(tx_data), 32'(front(m_ch)));
                chk("R6 tx_last", 32'(tx_last), 32'(m_rem == 1));
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk); #1;
        reg_we = 1'b1; reg_waddr = 4'(a); reg_wdata = d;
        @(posedge clk); #1;
        reg_we = 1'b0;
    endtask

    task automatic rd(input int a, input string tag);
        @(negedge clk); #1;
        reg_raddr = 4'(a);
        #1;
        chk(tag, reg_rdata, m_read(a));
    endtask

    task automatic rd_exp(input int a, input logic [31:0] exp, input string tag);
        @(negedge clk); #1;
        reg_raddr = 4'(a);
        #1;
        chk(tag, reg_rdata, exp);
    endtask

    task automatic drain(input int mode);
        int k;
        k = 0;
        while (m_busy) begin
            @(negedge clk); #1;
            tx_ready = (mode == 0) ? 1'b1 : ((k % 3) != 1);
            k++;
        end
        @(negedge clk); #1;
        tx_ready = 1'b0;
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1 reset state
        for (int a = 0; a < 9; a++) rd_exp(a, 32'h0, "R1 reset register");
        @(negedge clk);
        chk("R1 tx_valid after reset", 32'(tx_valid), 32'h0);
        chk("R1 irq after reset", 32'(irq), 32'h0);

        // R2 queue select
        wr(1, 1); rd_exp(1, 1, "R2 select 1");
        wr(1, 5); rd_exp(1, 0, "R2 select out of range");
        wr(1, 1); wr(1, 2); rd_exp(1, 0, "R2 select 2 gives 0");

        // R3/R6/R7 basic frame on queue 0, always ready
        wr(0, 32'h2); wr(7, 32'h3);
        wr(2, 32'h4433_2211); wr(2, 32'h8877_6655); wr(2, 32'hCCBB_AA99);
        rd_exp(5, 12, "R3 fill after 3 words");
        wr(3, 10); rd_exp(3, 10, "R4 length stored");
        wr(5, 1);
        drain(0);
        rd_exp(5, 0, "R6 leftover bytes discarded");
        rd_exp(3, 0, "R6 length cleared");
        rd_exp(8, 1, "R7 status bit 0");
        @(negedge clk);
        chk("R8 irq set", 32'(irq), 32'h1);

        // R9 write-one-to-clear
        wr(8, 32'h2); rd_exp(8, 1, "R9 other bit kept");
        wr(8, 32'h1); rd_exp(8, 0, "R9 bit cleared");

        // R3 overflow and R4 clamp on queue 1
        wr(1, 1);
        for (int i = 0; i < DEPTH / 4; i++) wr(2, 32'h0302_0100 + 32'h0404_0404 * i);
        rd_exp(6, DEPTH, "R3 queue full");
        wr(2, 32'hDEAD_BEEF);
        rd_exp(6, DEPTH, "R3 word dropped when full");
        wr(4, 1000); rd_exp(4, DEPTH, "R4 clamp to DEPTH");

        // R5 disabled start ignored
        wr(0, 32'h0); wr(6, 1);
        @(negedge clk);
        chk("R5 start ignored when disabled", 32'(tx_valid), 32'h0);
        wr(0, 32'h2);
        wr(6, 32'h2);
        @(negedge clk);
        chk("R5 start needs bit 0", 32'(tx_valid), 32'h0);

        // R6 frame with back-pressure
        wr(6, 1);
        drain(1);
        rd_exp(8, 2, "R7 status bit 1");
        rd_exp(6, 0, "R6 queue 1 empty");

        // R5 length limited to fill level
        wr(1, 0); wr(3, 20);
        wr(2, 32'h1234_5678); wr(2, 32'h9ABC_DEF0);
        wr(5, 1);
        drain(0);
        rd_exp(8, 3, "R7 both bits");

        // R5 zero length ignored
        wr(2, 32'h5555_AAAA);
        wr(5, 1);
        @(negedge clk);
        chk("R5 zero length ignored", 32'(tx_valid), 32'h0);
        rd(5, "R5 fill unchanged");

        // R5 start while busy ignored
        wr(3, 4);
        wr(1, 1); wr(2, 32'h0F0E_0D0C); wr(4, 4);
        wr(5, 1);
        wr(6, 1);
        rd_exp(6, 4, "R5 queue 1 untouched while busy");
        drain(0);
        rd_exp(6, 4, "R5 queue 1 still held");
        wr(8, 32'h3); wr(6, 1); drain(1);
        rd_exp(8, 2, "R7 queue 1 after busy");

        // R8 masked interrupt
        wr(7, 32'h1);
        @(negedge clk);
        chk("R8 masked status", 32'(irq), 32'h0);

        // R10 soft reset mid-frame
        wr(1, 0);
        for (int i = 0; i < 8; i++) wr(2, 32'hA5A5_0000 + i);
        wr(3, 32); wr(5, 1);
        @(negedge clk); #1 tx_ready = 1'b1;
        @(negedge clk); #1 tx_ready = 1'b0;
        wr(0, 32'h3);
        @(negedge clk);
        chk("R10 stream cut", 32'(tx_valid), 32'h0);
        rd_exp(0, 32'h2, "R10 enable kept, reset bit not stored");
        rd_exp(5, 0, "R10 queue 0 cleared");
        rd_exp(8, 0, "R10 status cleared");
        rd_exp(7, 0, "R10 enable mask cleared");
        rd_exp(3, 0, "R10 length cleared");

        repeat (3) @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule